// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block runs a short stored program that saves or restores a hardware context. A host fills a 256-word instruction store through two write strobes. One strobe sets the write index. The other writes a word at that index and then steps the index on by one. After a start pulse the sequencer fetches words from address 0 and executes one instruction per cycle. Block transfers and waits take more than one cycle.

The instructions work on one 128-entry flag space. They can branch on a flag, wait for a flag to reach a given value, or write a flag. Some flags mirror live inputs: the busy status, the two automatic save and load requests, and a constant one. The two user request flags are sticky internal bits. A request pulse sets them and the program clears them. Flag 0 sets the direction of every block transfer. A block-transfer instruction moves a run of consecutive register indices to or from context memory. It uses a request/acknowledge port and steps a position pointer for each word. Fixed command words end the program or raise one-cycle pulses that advance context pointers elsewhere in the chip. A 20-bit state register can be loaded from an immediate.

Top module: `ctx_seq`

## Requirements
- R1: Writing the index strobe sets the store's write index, and each data strobe stores the word and adds one to the index. After start the program runs from address 0.
- R2: Index and data writes have no effect while the sequencer is running (the `running` output is 1).
- R3: A branch has 0x4 in bits 23:20, a target in bits 15:8, a polarity in bit 7 and a flag index in bits 6:0. It jumps to the target when the flag equals the polarity, and otherwise goes on to the next word.
- R4: Flag 96 reads `busyIn`, flag 100 reads `autoSaveIn`, flag 101 reads `autoLoadIn` and flag 104 always reads 1. Set instructions aimed at these four indices are ignored.
- R5: A wait (0x5 in bits 23:20) holds the program at that word until the flag at bits 6:0 equals bit 7.
- R6: A set (0x7 in bits 23:20) writes bit 7 into an internal flag. A pulse on `userSaveReq` or `userLoadReq` sets flag 5 or flag 6.
- R7: A word with bits 23:22 equal to 0 and bit 21 set loads bits 19:0 into `stateReg`.
- R8: A transfer (0x1 in bits 23:20) moves the count in bits 19:14 of words, starting at the register index in bits 13:0. Each acknowledged handshake moves one word and adds one to both the register index and the position. `xferSave` equals flag 0 (1 = save, 0 = load).
- R9: A transfer with a count of 0 makes no handshake and goes on to the next word.
- R10: Command words 0x600007, 0x600009 and 0x60000A each raise `nextToSwap`, `nextToCurrent` or `setCtxPtr` for exactly one cycle.
- R11: Word 0x60000E stops the program and holds `done` high until the next start. Encodings not listed here take one cycle and do nothing.
- R12: Start sets the program counter and the position pointer to 0 and clears `done`.
- R13: After reset, `done`, `running`, `xferReq`, all pulses and `stateReg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts the program at address 0 |
| progIdxWe | input | 1 | Sets the store write index from progWdata |
| progDataWe | input | 1 | Writes progWdata into the store and steps the index |
| progWdata | input | 24 | Host write data |
| busyIn | input | 1 | Busy status, read as flag 96 |
| autoSaveIn | input | 1 | Automatic save request, read as flag 100 |
| autoLoadIn | input | 1 | Automatic load request, read as flag 101 |
| userSaveReq | input | 1 | Pulse that sets flag 5 |
| userLoadReq | input | 1 | Pulse that sets flag 6 |
| xferAck | input | 1 | Acknowledges one transfer word |
| xferReq | output | 1 | A transfer word is pending |
| xferSave | output | 1 | Direction: 1 = register to memory, 0 = memory to register |
| xferReg | output | 14 | Register index of the current word |
| xferPos | output | 16 | Context-memory position of the current word |
| stateReg | output | 20 | State register |
| nextToSwap | output | 1 | One-cycle command pulse |
| nextToCurrent | output | 1 | One-cycle command pulse |
| setCtxPtr | output | 1 | One-cycle command pulse |
| running | output | 1 | The program is executing |
| done | output | 1 | The program reached its end command |

## Verification
A wrong flag bit or wrong program counter shows up as a different final `stateReg` value when `done` rises, because each test program ends on a path-specific immediate. A wrong direction, count or pointer shows up at the first handshake, in the logged `xferReg`, `xferPos` and `xferSave` values. A stray or missing command pulse changes the per-run pulse counts. A store that takes writes while running changes which word runs after a stalled wait is released.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  localparam int INSTR_W = 24;
  localparam int FLAG_N  = 128;
  localparam int FIDX_W  = 7;
  localparam int SR_W    = 20;
  localparam int REG_W   = 14;
  localparam int CNT_W   = 6;

  localparam logic [FIDX_W-1:0] FLAG_DIR   = 7'd0;
  localparam logic [FIDX_W-1:0] FLAG_USAVE = 7'd5;
  localparam logic [FIDX_W-1:0] FLAG_ULOAD = 7'd6;
  localparam logic [FIDX_W-1:0] FLAG_BUSY  = 7'd96;
  localparam logic [FIDX_W-1:0] FLAG_ASAVE = 7'd100;
  localparam logic [FIDX_W-1:0] FLAG_ALOAD = 7'd101;
  localparam logic [FIDX_W-1:0] FLAG_ONE   = 7'd104;

  localparam logic [INSTR_W-1:0] CMD_SWAP = 24'h600007;
  localparam logic [INSTR_W-1:0] CMD_CUR  = 24'h600009;
  localparam logic [INSTR_W-1:0] CMD_PTR  = 24'h60000A;
  localparam logic [INSTR_W-1:0] CMD_END  = 24'h60000E;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_XFER, ST_DONE} seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              flagWe;
    logic [FIDX_W-1:0] flagIdx;
    logic              flagVal;
    logic              srLoad;
    logic              xferLoad;
    logic              xferStep;
    logic              posClr;
    logic              pulseSwap;
    logic              pulseCur;
    logic              pulsePtr;
  } seqStrobe_t;
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                flagBit,
  input  logic                xferAck,
  output logic [ADDR_W-1:0]   pc,
  output seqStrobe_t          strobe,
  output logic                xferReq,
  output logic                running,
  output logic                done
);
  seqState_e         st, stNext;
  logic [ADDR_W-1:0] pcNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [3:0]        opc;
  logic [CNT_W-1:0]  wordCnt;
  logic              condMet;

  assign opc     = instr[23:20];
  assign wordCnt = instr[19:14];
  assign condMet = (flagBit == instr[7]);

  always_comb begin
    strobe = '0;
    stNext = st;
    pcNext = pc;
    cntNext = cnt;
    if (start) begin
      strobe.posClr = 1'b1;
    end else begin
      unique case (st)
        ST_EXEC: begin
          pcNext = pc + 1'b1;
          if (opc == 4'h4) begin
            if (condMet) pcNext = ADDR_W'(instr[15:8]);
          end else if (opc == 4'h5) begin
            if (!condMet) pcNext = pc;
          end else if (opc == 4'h7) begin
            strobe.flagWe  = 1'b1;
            strobe.flagIdx = instr[6:0];
            strobe.flagVal = instr[7];
          end else if (opc[3:1] == 3'b001) begin
            strobe.srLoad = 1'b1;
          end else if (opc == 4'h1) begin
            if (wordCnt != '0) begin
              strobe.xferLoad = 1'b1;
              cntNext = wordCnt;
              stNext = ST_XFER;
              pcNext = pc;
            end
          end else if (instr == CMD_END) begin
            stNext = ST_DONE;
            pcNext = pc;
          end else if (instr == CMD_SWAP) begin
            strobe.pulseSwap = 1'b1;
          end else if (instr == CMD_CUR) begin
            strobe.pulseCur = 1'b1;
          end else if (instr == CMD_PTR) begin
            strobe.pulsePtr = 1'b1;
          end
        end
        ST_XFER: begin
          if (xferAck) begin
            strobe.xferStep = 1'b1;
            cntNext = cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
              stNext = ST_EXEC;
              pcNext = pc + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      pc  <= '0;
      cnt <= '0;
    end else if (start) begin
      st  <= ST_EXEC;
      pc  <= '0;
      cnt <= '0;
    end else begin
      st  <= stNext;
      pc  <= pcNext;
      cnt <= cntNext;
    end
  end

  assign xferReq = (st == ST_XFER);
  assign running = (st == ST_EXEC) || (st == ST_XFER);
  assign done    = (st == ST_DONE);
endmodule

// File: rtl/ctx_seq_dp.sv
module ctx_seq_dp
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  pc,
  input  logic               running,
  input  logic               progIdxWe,
  input  logic               progDataWe,
  input  logic [INSTR_W-1:0] progWdata,
  input  logic               busyIn,
  input  logic               autoSaveIn,
  input  logic               autoLoadIn,
  input  logic               userSaveReq,
  input  logic               userLoadReq,
  output logic [INSTR_W-1:0] instr,
  output logic               flagBit,
  output logic [SR_W-1:0]    stateReg,
  output logic [REG_W-1:0]   xferReg,
  output logic [POS_W-1:0]   xferPos,
  output logic               xferSave,
  output logic               nextToSwap,
  output logic               nextToCurrent,
  output logic               setCtxPtr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [INSTR_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0]  hostIdx;
  logic [FLAG_N-1:0]  flagReg;
  logic [FLAG_N-1:0]  flagView;
  logic               hostOk;
  logic               flagRo;

  assign hostOk = !running;
  assign instr  = store[pc];

  always_ff @(posedge clk) begin
    if (progDataWe && hostOk) store[hostIdx] <= progWdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hostIdx <= '0;
    else if (hostOk && progIdxWe) hostIdx <= progWdata[ADDR_W-1:0];
    else if (hostOk && progDataWe) hostIdx <= hostIdx + 1'b1;
  end

  // live inputs and the constant overlay the stored flag bits
  always_comb begin
    flagView = flagReg;
    flagView[FLAG_BUSY]  = busyIn;
    flagView[FLAG_ASAVE] = autoSaveIn;
    flagView[FLAG_ALOAD] = autoLoadIn;
    flagView[FLAG_ONE]   = 1'b1;
  end
  assign flagBit  = flagView[instr[6:0]];
  assign xferSave = flagView[FLAG_DIR];
  assign flagRo   = (strobe.flagIdx == FLAG_BUSY) || (strobe.flagIdx == FLAG_ASAVE) ||
                    (strobe.flagIdx == FLAG_ALOAD) || (strobe.flagIdx == FLAG_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flagReg <= '0;
    else begin
      if (strobe.flagWe && !flagRo) flagReg[strobe.flagIdx] <= strobe.flagVal;
      if (userSaveReq) flagReg[FLAG_USAVE] <= 1'b1;
      if (userLoadReq) flagReg[FLAG_ULOAD] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateReg      <= '0;
      xferReg       <= '0;
      xferPos       <= '0;
      nextToSwap    <= 1'b0;
      nextToCurrent <= 1'b0;
      setCtxPtr     <= 1'b0;
    end else begin
      if (strobe.srLoad) stateReg <= instr[SR_W-1:0];
      if (strobe.xferLoad) xferReg <= instr[REG_W-1:0];
      else if (strobe.xferStep) xferReg <= xferReg + 1'b1;
      if (strobe.posClr) xferPos <= '0;
      else if (strobe.xferStep) xferPos <= xferPos + 1'b1;
      nextToSwap    <= strobe.pulseSwap;
      nextToCurrent <= strobe.pulseCur;
      setCtxPtr     <= strobe.pulsePtr;
    end
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               progIdxWe,
  input  logic               progDataWe,
  input  logic [INSTR_W-1:0] progWdata,
  input  logic               busyIn,
  input  logic               autoSaveIn,
  input  logic               autoLoadIn,
  input  logic               userSaveReq,
  input  logic               userLoadReq,
  input  logic               xferAck,
  output logic               xferReq,
  output logic               xferSave,
  output logic [REG_W-1:0]   xferReg,
  output logic [POS_W-1:0]   xferPos,
  output logic [SR_W-1:0]    stateReg,
  output logic               nextToSwap,
  output logic               nextToCurrent,
  output logic               setCtxPtr,
  output logic               running,
  output logic               done
);
  seqStrobe_t         strobe;
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] instr;
  logic               flagBit;

  ctx_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .flagBit(flagBit),
    .xferAck(xferAck), .pc(pc), .strobe(strobe), .xferReq(xferReq),
    .running(running), .done(done)
  );

  ctx_seq_dp #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pc(pc), .running(running),
    .progIdxWe(progIdxWe), .progDataWe(progDataWe), .progWdata(progWdata),
    .busyIn(busyIn), .autoSaveIn(autoSaveIn), .autoLoadIn(autoLoadIn),
    .userSaveReq(userSaveReq), .userLoadReq(userLoadReq), .instr(instr),
    .flagBit(flagBit), .stateReg(stateReg), .xferReg(xferReg), .xferPos(xferPos),
    .xferSave(xferSave), .nextToSwap(nextToSwap), .nextToCurrent(nextToCurrent),
    .setCtxPtr(setCtxPtr)
  );
endmodule

// File: rtl/ctx_seq_chk.sv
module ctx_seq_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             xferReq,
  input logic             xferAck,
  input logic [13:0]      xferReg,
  input logic [POS_W-1:0] xferPos,
  input logic [19:0]      stateReg,
  input logic             nextToSwap,
  input logic             nextToCurrent,
  input logic             setCtxPtr,
  input logic             running,
  input logic             done
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xferReq && !xferAck && !start) |=> (xferReq && $stable(xferReg) && $stable(xferPos)));

  assert_pos_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xferReq && xferAck && !start) |=> (xferPos == $past(xferPos) + 1'b1));

  assert_req_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xferReq |-> running);

  assert_pulse_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nextToSwap, nextToCurrent, setCtxPtr}));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && !xferReq));

  assert_sr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(stateReg));
endmodule

bind ctx_seq ctx_seq_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .xferReq(xferReq), .xferAck(xferAck),
  .xferReg(xferReg), .xferPos(xferPos), .stateReg(stateReg), .nextToSwap(nextToSwap),
  .nextToCurrent(nextToCurrent), .setCtxPtr(setCtxPtr), .running(running), .done(done)
);

// File: tb/ctx_seq_tb.sv
`timescale 1ns/1ps
module ctx_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, progIdxWe = 1'b0, progDataWe = 1'b0;
  logic [23:0] progWdata = '0;
  logic busyIn = 1'b0, autoSaveIn = 1'b0, autoLoadIn = 1'b0;
  logic userSaveReq = 1'b0, userLoadReq = 1'b0, xferAck = 1'b0;
  logic xferReq, xferSave, nextToSwap, nextToCurrent, setCtxPtr, running, done;
  logic [13:0] xferReg;
  logic [15:0] xferPos;
  logic [19:0] stateReg;

  always #2 clk = ~clk;

  ctx_seq u_dut (.*);

  int nChecks = 0, nFails = 0;
  int logN = 0, nSwap = 0, nCur = 0, nPtr = 0;
  logic [13:0] logReg [64];
  logic [15:0] logPos [64];
  logic        logSave [64];
  logic [23:0] prog [32];

  // acknowledge responder and event log
  always @(negedge clk) begin
    if (xferReq && !xferAck) begin
      if (logN < 64) begin
        logReg[logN] = xferReg; logPos[logN] = xferPos; logSave[logN] = xferSave;
      end
      logN = logN + 1;
      xferAck <= 1'b1;
    end else xferAck <= 1'b0;
    if (nextToSwap) nSwap = nSwap + 1;
    if (nextToCurrent) nCur = nCur + 1;
    if (setCtxPtr) nPtr = nPtr + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] bra(input int idx, input logic pol, input int tgt);
    return {4'h4, 4'h0, 8'(tgt), pol, 7'(idx)};
  endfunction
  function automatic logic [23:0] wt(input int idx, input logic pol);
    return {4'h5, 12'h0, pol, 7'(idx)};
  endfunction
  function automatic logic [23:0] st(input int idx, input logic val);
    return {4'h7, 12'h0, val, 7'(idx)};
  endfunction
  function automatic logic [23:0] lsr(input int v);
    return {4'h2, 20'(v)};
  endfunction
  function automatic logic [23:0] xf(input int cnt, input int rg);
    return {4'h1, 6'(cnt), 14'(rg)};
  endfunction

  task automatic load(input int n);
    @(negedge clk); progIdxWe = 1'b1; progWdata = 24'h0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); progIdxWe = 1'b0; progDataWe = 1'b1; progWdata = prog[i];
    end
    @(negedge clk); progDataWe = 1'b0; progIdxWe = 1'b0;
  endtask

  task automatic run(output logic ok);
    logN = 0; nSwap = 0; nCur = 0; nPtr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // {busy, autoSave, autoLoad, polarity, expectTaken, flagIdx[6:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd104},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd104},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 7'd96},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd96},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd100},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd101},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd0},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(done == 0 && running == 0, "R13 done/running", {done, running}, 0);
    check(xferReq == 0, "R13 xferReq", xferReq, 0);
    check(stateReg == 0, "R13 stateReg", stateReg, 0);
    check({nextToSwap, nextToCurrent, setCtxPtr} == 0, "R13 pulses",
          {nextToSwap, nextToCurrent, setCtxPtr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 branch vectors
    prog[1] = lsr(24'h11111); prog[2] = 24'h60000E;
    prog[3] = lsr(24'h22222); prog[4] = 24'h60000E;
    foreach (VEC[v]) begin
      prog[0] = bra(VEC[v][6:0], VEC[v][8], 3);
      busyIn = VEC[v][11]; autoSaveIn = VEC[v][10]; autoLoadIn = VEC[v][9];
      load(5);
      run(ok);
      check(ok && stateReg == (VEC[v][7] ? 20'h22222 : 20'h11111), "R3 R4 branch vector",
            stateReg, VEC[v][7] ? 20'h22222 : 20'h11111);
    end
    busyIn = 1'b0; autoSaveIn = 1'b0; autoLoadIn = 1'b0;

    // R1 R7 R8 R9 R10 R11 main program
    prog[0] = st(0, 1);         prog[1] = xf(3, 14'h123);
    prog[2] = xf(0, 14'h300);   prog[3] = xf(2, 14'h200);
    prog[4] = 24'h600007;       prog[5] = 24'h600009;
    prog[6] = 24'h60000A;       prog[7] = 24'h800001;
    prog[8] = st(0, 0);         prog[9] = xf(1, 14'h040);
    prog[10] = lsr(20'hABCDE);  prog[11] = 24'h60000E;
    load(12);
    run(ok);
    check(ok && done, "R11 done after end", done, 1);
    check(logN == 6, "R9 handshake count (zero-count skipped)", logN, 6);
    begin
      logic [13:0] er [6] = '{14'h123, 14'h124, 14'h125, 14'h200, 14'h201, 14'h040};
      logic        es [6] = '{1, 1, 1, 1, 1, 0};
      for (int i = 0; i < 6; i++)
        check(logReg[i] == er[i] && logPos[i] == 16'(i) && logSave[i] == es[i],
              "R8 transfer word", {logReg[i], logPos[i], 3'b0, logSave[i]},
              {er[i], 16'(i), 3'b0, es[i]});
    end
    check(nSwap == 1 && nCur == 1 && nPtr == 1, "R10 pulse counts",
          {nSwap[3:0], nCur[3:0], nPtr[3:0]}, 12'h111);
    check(stateReg == 20'hABCDE, "R7 R11 stateReg after no-op", stateReg, 20'hABCDE);

    // R12 restart resets pc, position and done
    @(negedge clk); start = 1'b1; logN = 0;
    @(negedge clk); start = 1'b0;
    check(done == 0, "R12 done cleared by start", done, 0);
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    check(logN == 6 && logPos[0] == 0 && logPos[5] == 5, "R12 position restarts",
          logPos[0], 0);

    // R5 R2 wait stall and write blocking
    prog[0] = wt(96, 0); prog[1] = lsr(20'h00055); prog[2] = 24'h60000E;
    load(3);
    busyIn = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    check(!done && running, "R5 stalled while busy", {done, running}, 1);
    check(stateReg == 20'hABCDE, "R5 no progress while stalled", stateReg, 20'hABCDE);
    progIdxWe = 1'b1; progWdata = 24'h0;
    @(negedge clk); progIdxWe = 1'b0; progDataWe = 1'b1; progWdata = 24'h60000E;
    @(negedge clk); progDataWe = 1'b0;
    busyIn = 1'b0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    check(done && stateReg == 20'h00055, "R2 R5 store unchanged, wait released",
          stateReg, 20'h00055);

    // R6 R4 user flag and read-only flag writes
    @(negedge clk); userSaveReq = 1'b1;
    @(negedge clk); userSaveReq = 1'b0;
    prog[0] = bra(5, 1, 3);  prog[1] = lsr(1);   prog[2] = 24'h60000E;
    prog[3] = st(5, 0);      prog[4] = st(104, 0); prog[5] = bra(104, 1, 8);
    prog[6] = lsr(2);        prog[7] = 24'h60000E; prog[8] = bra(5, 0, 11);
    prog[9] = lsr(3);        prog[10] = 24'h60000E; prog[11] = lsr(4);
    prog[12] = 24'h60000E;
    load(13);
    run(ok);
    check(ok && stateReg == 20'h4, "R6 R4 flag set/clear and read-only", stateReg, 4);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule